// File: doc/BRIEF.md
# Register Number Translator with Bank Protection

This block sits between instruction decode and a 256-entry general register file. Each instruction carries three 8-bit register fields: source A, source B and destination. The block turns each field into an absolute register-file address. A field with its top bit clear selects a global register directly. A field with its top bit set selects a local register. The local address is taken relative to a 7-bit window base, which is a shadow of the stack pointer held in register 1. A field value of zero does not name a register. Instead it selects that operand's own indirect pointer, and the pointer is used as given with no base offset.

The three translated addresses are checked against a 16-bit bank mask while the processor runs in user mode. Each bank holds sixteen registers and is named by the top four address bits. The translator also owns the state that translation needs: the shadow window base, a flag marking it untrustworthy, and the three indirect pointers. The pointers can be loaded one at a time by a special-register move, or all together by a pointer-setting instruction that stores the translated fields of the current cycle.

Top module: `regnum_xlate`

## Requirements
- R1: A field with bit 7 equal to 0 and a value other than 0 yields an absolute number equal to the field value, in the same cycle.
- R2: A field with bit 7 equal to 1 yields {1, (field[6:0] + base) mod 128}, where base is the 7-bit shadow window base.
- R3: A field equal to 0 yields that operand's own indirect pointer (source A, source B and destination each have their own). No base is added to the pointer.
- R4: The window base is loaded from bits 8..2 of the written value only when a register-1 write is flagged as arithmetic or logical. The new base is used from the next cycle. A write of any other class leaves the base unchanged.
- R5: `sp_invalid` is 0 after reset. It becomes 1 in the cycle after a register-1 write of a class other than arithmetic or logical. It returns to 0 in the cycle after an arithmetic or logical write.
- R6: `prot_fault` is 1 in a cycle exactly when `priv` is 0 and at least one of the three absolute numbers lies in a bank n (bank = bits 7..4) whose mask bit n is 1. When `priv` is 1, the fault is always 0.
- R7: A special-register move loads one pointer from bits 9..2 of `mtsr_data`. The target is chosen by `mtsr_sel`: 0 for source A, 1 for source B, 2 for destination, and 3 for none. The new value is used from the next cycle, and a translation in the same cycle sees the old value. The loaded value plays no part in that cycle's fault.
- R8: `ptr_set` loads all three pointers with that cycle's absolute numbers, visible from the next cycle. In the same cycle, those numbers are checked under R6. If `ptr_set` and a special-register move arrive together, `ptr_set` takes priority.
- R9: After reset, the three pointers and the window base are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 1 | 1 = supervisor mode, 0 = user mode |
| src_a_num | input | 8 | Source A register field |
| src_b_num | input | 8 | Source B register field |
| dst_num | input | 8 | Destination register field |
| prot_mask | input | 16 | Bank protect mask, bit n guards bank n |
| sp_wr_en | input | 1 | Result is being written to register 1 |
| sp_wr_alu | input | 1 | That write comes from an arithmetic or logical instruction |
| sp_wr_data | input | 32 | Value written to register 1 |
| mtsr_en | input | 1 | Special-register move to one pointer |
| mtsr_sel | input | 2 | Pointer chosen by the move (3 = none) |
| mtsr_data | input | 32 | Source value of the move |
| ptr_set | input | 1 | Load all pointers with this cycle's translations |
| abs_a | output | 8 | Absolute number for source A |
| abs_b | output | 8 | Absolute number for source B |
| abs_d | output | 8 | Absolute number for destination |
| prot_fault | output | 1 | User-mode bank protection violation |
| sp_invalid | output | 1 | Window base no longer matches register 1 |

## Verification
The hardest case to reach from the ports is the interaction between pointer state and translation timing. A pointer that has just been loaded must not be seen in its own cycle. A simultaneous `ptr_set` must override a move. A move that names a protected bank must not fault until a later zero field actually selects that pointer. The stimulus reaches these cases in three steps. It first places known pointer values through moves, observing each one only through a zero field. It then issues a `ptr_set` whose fields mix local, global and indirect operands while a move is also present. Finally, it loads a pointer into a protected bank and reads it back one cycle later in user mode. Local wraparound is driven with a base of 100 and offsets around 27 and 28, so that the 7-bit sum crosses 127.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
    localparam int RN_W   = 8;
    localparam int N_OPS  = 3;
    localparam int BANK_W = 4;
    localparam int N_BANK = 1 << BANK_W;
    localparam int OFS_W  = RN_W - 1;

    typedef logic [RN_W-1:0] rnum_t;

    typedef struct packed {
        logic [N_OPS-1:0][RN_W-1:0] ptr;
        logic [OFS_W-1:0]           base;
        logic                       base_bad;
    } xl_state_t;
endpackage

// File: rtl/rxl_xlate.sv
module rxl_xlate
    import rxl_pkg::*;
(
    input  logic [RN_W-1:0]  field,
    input  logic [RN_W-1:0]  ptr,
    input  logic [OFS_W-1:0] base,
    output logic [RN_W-1:0]  abs_num
);
    logic [OFS_W-1:0] win_sum;

    always_comb begin
        win_sum = field[OFS_W-1:0] + base;
        if (field == '0)
            abs_num = ptr;
        else if (field[RN_W-1])
            abs_num = {1'b1, win_sum};
        else
            abs_num = field;
    end
endmodule

// File: rtl/rxl_guard.sv
module rxl_guard
    import rxl_pkg::*;
(
    input  logic                           priv,
    input  logic [N_BANK-1:0]              mask,
    input  logic [N_OPS-1:0][BANK_W-1:0]   bank,
    output logic                           fault
);
    logic [N_OPS-1:0] hit;

    for (genvar i = 0; i < N_OPS; i++) begin : g_hit
        assign hit[i] = mask[bank[i]];
    end

    assign fault = !priv && (|hit);
endmodule

// File: rtl/regnum_xlate.sv
module regnum_xlate
    import rxl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PTR_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv,
    input  logic [7:0]        src_a_num,
    input  logic [7:0]        src_b_num,
    input  logic [7:0]        dst_num,
    input  logic [15:0]       prot_mask,
    input  logic              sp_wr_en,
    input  logic              sp_wr_alu,
    input  logic [DATA_W-1:0] sp_wr_data,
    input  logic              mtsr_en,
    input  logic [1:0]        mtsr_sel,
    input  logic [DATA_W-1:0] mtsr_data,
    input  logic              ptr_set,
    output logic [7:0]        abs_a,
    output logic [7:0]        abs_b,
    output logic [7:0]        abs_d,
    output logic              prot_fault,
    output logic              sp_invalid
);
    localparam int BASE_HI = PTR_LSB + OFS_W - 1;
    localparam int PTR_HI  = PTR_LSB + RN_W - 1;

    xl_state_t st_d, st_q;

    logic [N_OPS-1:0][RN_W-1:0]   fld;
    logic [N_OPS-1:0][RN_W-1:0]   absn;
    logic [N_OPS-1:0][BANK_W-1:0] bank;
    logic                         spare_unused;

    assign fld[0] = src_a_num;
    assign fld[1] = src_b_num;
    assign fld[2] = dst_num;

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        rxl_xlate u_xl (
            .field   (fld[i]),
            .ptr     (st_q.ptr[i]),
            .base    (st_q.base),
            .abs_num (absn[i])
        );
        assign bank[i] = absn[i][RN_W-1 -: BANK_W];
    end

    rxl_guard u_guard (
        .priv  (priv),
        .mask  (prot_mask),
        .bank  (bank),
        .fault (prot_fault)
    );

    assign abs_a        = absn[0];
    assign abs_b        = absn[1];
    assign abs_d        = absn[2];
    assign sp_invalid   = st_q.base_bad;
    assign spare_unused = ^{sp_wr_data, mtsr_data};

    always_comb begin
        st_d = st_q;
        if (sp_wr_en) begin
            if (sp_wr_alu) begin
                st_d.base     = sp_wr_data[BASE_HI:PTR_LSB];
                st_d.base_bad = 1'b0;
            end else begin
                st_d.base_bad = 1'b1;
            end
        end
        if (ptr_set) begin
            st_d.ptr = absn;
        end else if (mtsr_en && (32'(mtsr_sel) < N_OPS)) begin
            st_d.ptr[mtsr_sel] = mtsr_data[PTR_HI:PTR_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_d_reset();
        else        st_q <= st_d;
    end

    task automatic st_d_reset();
        st_q <= '0;
    endtask

    // R1
    glob_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_a_num[7] && src_a_num != 8'd0) |-> abs_a == src_a_num);

    // R2
    local_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_num[7] |-> abs_d[7]);

    // R6
    super_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv |-> !prot_fault);

    // R7
    mtsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtsr_en && !ptr_set && mtsr_sel == 2'd0)
        |=> (src_a_num != 8'd0 || abs_a == $past(mtsr_data[PTR_HI:PTR_LSB])));

    // R5
    sp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !sp_wr_alu) |=> sp_invalid);

    // R8
    ptr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_set |=> (st_q.ptr[1] == $past(absn[1])));
endmodule

// File: tb/regnum_xlate_test.sv
`timescale 1ns/1ps
module regnum_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        priv;
    logic [7:0]  src_a_num, src_b_num, dst_num;
    logic [15:0] prot_mask;
    logic        sp_wr_en, sp_wr_alu;
    logic [31:0] sp_wr_data;
    logic        mtsr_en;
    logic [1:0]  mtsr_sel;
    logic [31:0] mtsr_data;
    logic        ptr_set;
    logic [7:0]  abs_a, abs_b, abs_d;
    logic        prot_fault, sp_invalid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    regnum_xlate uut (
        .clk(clk), .rst_n(rst_n), .priv(priv),
        .src_a_num(src_a_num), .src_b_num(src_b_num), .dst_num(dst_num),
        .prot_mask(prot_mask), .sp_wr_en(sp_wr_en), .sp_wr_alu(sp_wr_alu),
        .sp_wr_data(sp_wr_data), .mtsr_en(mtsr_en), .mtsr_sel(mtsr_sel),
        .mtsr_data(mtsr_data), .ptr_set(ptr_set),
        .abs_a(abs_a), .abs_b(abs_b), .abs_d(abs_d),
        .prot_fault(prot_fault), .sp_invalid(sp_invalid)
    );

    // {a, b, d, mask, exp_a, exp_b, exp_d, priv, exp_fault}
    // base = 100, pointers A=0x20 B=0x41 D=0xF3
    localparam int NV = 8;
    localparam logic [71:0] VEC [NV] = '{
        72'h45_7F_40_0000_45_7F_40_0_0,
        72'h81_9C_FF_0000_E5_80_E3_0_0,
        72'h00_00_00_0004_20_41_F3_0_1,
        72'h00_00_00_0004_20_41_F3_1_0,
        72'h45_70_81_4000_45_70_E5_0_1,
        72'h45_70_81_3F6F_45_70_E5_0_0,
        72'h01_02_10_0002_01_02_10_0_1,
        72'h80_9B_7F_8000_E4_FF_7F_0_1
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sp_wr_en = 0; sp_wr_alu = 0; sp_wr_data = 0;
        mtsr_en = 0; mtsr_sel = 0; mtsr_data = 0; ptr_set = 0;
    endtask

    task automatic fields(logic [7:0] a, logic [7:0] b, logic [7:0] d);
        src_a_num = a; src_b_num = b; dst_num = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; priv = 0; prot_mask = 0;
        idle();
        fields(8'h00, 8'h80, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9 reset state
        chk("R9 ptr a", abs_a, 8'h00);
        chk("R9 base", abs_b, 8'h80);
        chk("R9 ptr d", abs_d, 8'h00);
        chk("R5 reset flag", {7'd0, sp_invalid}, 8'h00);

        // set base to 100
        @(negedge clk); sp_wr_en = 1; sp_wr_alu = 1; sp_wr_data = 32'h190;
        // R7 same-cycle old pointer
        @(negedge clk); idle(); mtsr_en = 1; mtsr_sel = 0; mtsr_data = 32'h80;
        fields(8'h00, 8'h00, 8'h00); #1;
        chk("R7 same cycle old", abs_a, 8'h00);
        @(negedge clk); mtsr_sel = 1; mtsr_data = 32'h104; #1;
        chk("R7 loaded next cycle", abs_a, 8'h20);
        @(negedge clk); mtsr_sel = 2; mtsr_data = 32'h3CC;
        @(negedge clk); mtsr_sel = 3; mtsr_data = 32'hFFC;
        @(negedge clk); idle(); #1;
        chk("R7 sel3 ignored a", abs_a, 8'h20);
        chk("R7 sel3 ignored b", abs_b, 8'h41);
        chk("R7 sel3 ignored d", abs_d, 8'hF3);

        // R1 R2 R3 R6 vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fields(VEC[i][71:64], VEC[i][63:56], VEC[i][55:48]);
            prot_mask = VEC[i][47:32];
            priv = VEC[i][4];
            #1;
            chk("R1/R2/R3 abs_a", abs_a, VEC[i][31:24]);
            chk("R1/R2/R3 abs_b", abs_b, VEC[i][23:16]);
            chk("R1/R2/R3 abs_d", abs_d, VEC[i][15:8]);
            chk("R6 fault", {7'd0, prot_fault}, {7'd0, VEC[i][0]});
        end

        // R4 R5 non-arithmetic write
        @(negedge clk); priv = 0; prot_mask = 0;
        sp_wr_en = 1; sp_wr_alu = 0; sp_wr_data = 32'h3FC;
        fields(8'h81, 8'h45, 8'h45); #1;
        chk("R4 same cycle", abs_a, 8'hE5);
        @(negedge clk); idle(); #1;
        chk("R5 flag set", {7'd0, sp_invalid}, 8'h01);
        chk("R4 base kept", abs_a, 8'hE5);
        @(negedge clk); sp_wr_en = 1; sp_wr_alu = 1; sp_wr_data = 32'h0; #1;
        chk("R4 arith same cycle", abs_a, 8'hE5);
        @(negedge clk); idle(); #1;
        chk("R5 flag cleared", {7'd0, sp_invalid}, 8'h00);
        chk("R4 base zero", abs_a, 8'h81);

        // R8 pointer set, priority over move, fault at load
        @(negedge clk); ptr_set = 1; mtsr_en = 1; mtsr_sel = 0; mtsr_data = 32'h3FC;
        fields(8'h85, 8'h45, 8'h00); prot_mask = 16'h0100; #1;
        chk("R8 fault at load", {7'd0, prot_fault}, 8'h01);
        @(negedge clk); idle(); prot_mask = 0; fields(8'h00, 8'h00, 8'h00); #1;
        chk("R8 ptr a", abs_a, 8'h85);
        chk("R8 ptr b", abs_b, 8'h45);
        chk("R8 ptr d", abs_d, 8'hF3);

        // R7 move exempt from protection
        @(negedge clk); mtsr_en = 1; mtsr_sel = 1; mtsr_data = 32'h3FC;
        prot_mask = 16'h8000; fields(8'h45, 8'h46, 8'h47); #1;
        chk("R7 move no fault", {7'd0, prot_fault}, 8'h00);
        @(negedge clk); idle(); fields(8'h45, 8'h00, 8'h47); #1;
        chk("R7 ptr b new", abs_b, 8'hFF);
        chk("R6 fault via ptr", {7'd0, prot_fault}, 8'h01);

        @(negedge clk);
        finish_run();
    end
endmodule